// File: doc/BRIEF.md
# Multi-Dimensional DMA Address Generator

This block turns one transfer-request record into a stream of byte addresses for a DMA move of one to four dimensions. A record arrives on a valid/ready port as a 32-bit flags word, a start address, four 16-bit loop counts and three signed 32-bit strides. Level 0 is the innermost loop and advances the address by one byte per beat. Each outer level restarts its loop at its own base plus its signed stride, and every loop inside it starts again from zero.

Two trigger slots in the flags word can each hold back the stream until a pulse arrives on a chosen source. The slot's granularity sets how much one pulse releases: one pass of an inner block, or the whole request. An event pulse marks the points that the event-size field selects. When the request ends, a completion strobe reports a status code and the record's command ID. A record with a bad type or a zero inner count is rejected without producing any beats.

Top module: `nd_addr_gen`

## Requirements
- R1: `reqReady` is high only while no record is active. A record is taken at the clock edge where `reqValid` and `reqReady` are both high. An ungated accepted record shows its first beat in the next cycle, at `reqAddr`.
- R2: The flags word is decoded as follows: type in [3:0], event size in [7:6], slot 0 source in [9:8], slot 0 granularity in [11:10], slot 1 source in [13:12], slot 1 granularity in [15:14], command ID in [23:16]. Bits 4, 5 and [31:24] have no effect. The completion strobe returns the command ID on `doneCmd`.
- R3: Beat addresses follow `start + i0 + i1*s1 + i2*s2 + i3*s3`, taken modulo 2^32, with the level 0 index running fastest. The strides s1..s3 are signed.
- R4: A record of type t (0 to 3) loops over levels 0..t. Levels above t count as 1, and a count of 0 on a used outer level also counts as 1. The number of beats is the product of these counts.
- R5: `beatLast` is high on the final beat only. `doneValid` pulses for one cycle in the cycle after the final beat is taken, with `doneStatus` = 0.
- R6: A supported type with a level 0 count of 0 is rejected. It produces no beats, and `doneValid` pulses in the cycle after acceptance with `doneStatus` = 3.
- R7: Types 4 to 15 are rejected. They produce no beats, and `doneValid` pulses in the cycle after acceptance with `doneStatus` = 4. This takes precedence over R6.
- R8: If the event size is 0, or if the event size is larger than the type, exactly one `evtPulse` occurs, in the cycle after the final beat.
- R9: If the event size is e (1 to 3) and the type is at least e, `evtPulse` occurs in the cycle after each beat that ends a full pass of levels 0..e-1.
- R10: A slot with a nonzero source is active; source codes 1, 2 and 3 select `trigSrc` bits 0, 1 and 2. With granularity g, a beat whose indices on levels 0..min(g,3) are all zero waits for one stored pulse. Granularity 3 therefore gates only the first beat of the request. A pulse on an unselected source has no effect.
- R11: While `beatValid` is high and `beatReady` is low, the beat stays valid with the same address and last flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Record valid |
| reqReady | output | 1 | Block idle, record can be taken |
| reqFlags | input | 32 | Record flags word |
| reqAddr | input | ADDR_W | Start byte address |
| reqCnt | input | 4 x CNT_W | Loop counts, element l for level l |
| reqStride | input | 3 x STRIDE_W | Signed strides, element l for level l (1..3) |
| trigSrc | input | 3 | Trigger sources: global 0, global 1, local |
| beatValid | output | 1 | Address beat valid |
| beatReady | input | 1 | Beat consumer ready |
| beatAddr | output | ADDR_W | Byte address of the beat |
| beatLast | output | 1 | Final beat of the request |
| evtPulse | output | 1 | One-cycle event pulse |
| doneValid | output | 1 | One-cycle completion strobe |
| doneStatus | output | 4 | 0 ok, 3 zero inner count, 4 unsupported type |
| doneCmd | output | 8 | Command ID of the finished record |

## Verification
Each result has a fixed arrival time. The first beat of an ungated record is present one cycle after acceptance. `evtPulse` and `doneValid` follow the edge that takes the qualifying beat by one cycle. A reject completes one cycle after acceptance, and a trigger pulse opens the gate in the next cycle. The bench drives inputs and samples outputs on the falling edge. It notes which beat fires at the coming rising edge and checks the event and completion expectations for that beat at the next falling edge, against addresses and event flags computed from the closed-form formula.

// File: rtl/nd_addr_gen_pkg.sv
package nd_addr_gen_pkg;
  localparam int LEVELS = 4;
  localparam int LVL_W  = $clog2(LEVELS);
  localparam int SLOTS  = 2;

  // flags word field positions
  localparam int FL_TYPE_LO  = 0;
  localparam int FL_EVT_LO   = 6;
  localparam int FL_T0SEL_LO = 8;
  localparam int FL_T0GRN_LO = 10;
  localparam int FL_T1SEL_LO = 12;
  localparam int FL_T1GRN_LO = 14;
  localparam int FL_CMD_LO   = 16;

  typedef enum logic [3:0] {
    ST_OK         = 4'd0,
    ST_SUBMIT_ERR = 4'd3,
    ST_UNSUP_ERR  = 4'd4
  } status_e;

  typedef struct packed {
    logic             load;
    logic             advance;
    logic [LVL_W-1:0] level;
  } dp_strobe_t;

  function automatic logic [LEVELS-1:0] lowMask(input logic [LVL_W-1:0] topLvl);
    for (int l = 0; l < LEVELS; l++) lowMask[l] = (l <= int'(topLvl));
  endfunction
endpackage

// File: rtl/nd_addr_gen_ctrl.sv
module nd_addr_gen_ctrl
  import nd_addr_gen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         reqValid,
  output logic                         reqReady,
  input  logic [31:0]                  reqFlags,
  input  logic [LEVELS-1:0][CNT_W-1:0] reqCnt,
  input  logic [2:0]                   trigSrc,
  output logic                         beatValid,
  input  logic                         beatReady,
  output logic                         beatLast,
  output logic                         evtPulse,
  output logic                         doneValid,
  output logic [3:0]                   doneStatus,
  output logic [7:0]                   doneCmd,
  output dp_strobe_t                   strb
);
  logic running;
  logic [1:0] recType;
  logic [1:0] evtSize;
  logic [SLOTS-1:0][1:0] trigSel;
  logic [SLOTS-1:0][LVL_W-1:0] trigGran;
  logic [SLOTS-1:0] credit, chunkStart, trigHit, slotOk;
  logic [LEVELS-1:0][CNT_W-1:0] cntEff, idx, cntNext;
  logic [LEVELS-1:0] atMax, atZero;
  logic [LVL_W-1:0] carryLvl;
  logic finalBeat, fire, accept, evtNow;
  logic [3:0] inType;
  logic badType, badCnt;
  logic unusedFlags;

  assign unusedFlags = ^{reqFlags[31:24], reqFlags[5:4]};
  assign inType  = reqFlags[FL_TYPE_LO +: 4];
  assign badType = inType > 4'd3;
  assign badCnt  = reqCnt[0] == '0;
  assign reqReady = !running;
  assign accept   = reqValid && reqReady;

  always_comb begin
    for (int l = 0; l < LEVELS; l++) begin
      if (l == 0)                cntNext[l] = reqCnt[0];
      else if (l <= int'(inType)) cntNext[l] = (reqCnt[l] == '0) ? CNT_W'(1) : reqCnt[l];
      else                       cntNext[l] = CNT_W'(1);
    end
  end

  always_comb begin
    carryLvl = '0;
    for (int l = 0; l < LEVELS; l++) begin
      atMax[l]  = idx[l] == cntEff[l] - 1'b1;
      atZero[l] = idx[l] == '0;
    end
    for (int l = LEVELS - 1; l >= 0; l--) if (!atMax[l]) carryLvl = LVL_W'(l);
  end
  assign finalBeat = &atMax;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign chunkStart[s] = &(atZero | ~lowMask(trigGran[s]));
    assign trigHit[s] = (trigSel[s] == 2'd1 && trigSrc[0]) ||
                        (trigSel[s] == 2'd2 && trigSrc[1]) ||
                        (trigSel[s] == 2'd3 && trigSrc[2]);
    assign slotOk[s] = (trigSel[s] == 2'd0) || !chunkStart[s] || credit[s];
  end

  assign beatValid = running && (&slotOk);
  assign beatLast  = finalBeat;
  assign fire      = beatValid && beatReady;

  always_comb begin
    if (evtSize == 2'd0 || recType < evtSize) evtNow = finalBeat;
    else evtNow = &(atMax | ~lowMask(LVL_W'(evtSize - 2'd1)));
  end

  assign strb.load    = accept && !badType && !badCnt;
  assign strb.advance = fire && !finalBeat;
  assign strb.level   = carryLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running    <= 1'b0;
      recType    <= '0;
      evtSize    <= '0;
      trigSel    <= '0;
      trigGran   <= '0;
      credit     <= '0;
      cntEff     <= '0;
      idx        <= '0;
      evtPulse   <= 1'b0;
      doneValid  <= 1'b0;
      doneStatus <= ST_OK;
      doneCmd    <= '0;
    end else begin
      evtPulse  <= 1'b0;
      doneValid <= 1'b0;
      for (int s = 0; s < SLOTS; s++)
        credit[s] <= running && ((credit[s] && !(fire && chunkStart[s])) || trigHit[s]);
      if (accept) begin
        recType     <= inType[1:0];
        evtSize     <= reqFlags[FL_EVT_LO +: 2];
        trigSel[0]  <= reqFlags[FL_T0SEL_LO +: 2];
        trigSel[1]  <= reqFlags[FL_T1SEL_LO +: 2];
        trigGran[0] <= reqFlags[FL_T0GRN_LO +: LVL_W];
        trigGran[1] <= reqFlags[FL_T1GRN_LO +: LVL_W];
        doneCmd     <= reqFlags[FL_CMD_LO +: 8];
        cntEff      <= cntNext;
        idx         <= '0;
        if (badType) begin
          doneValid  <= 1'b1;
          doneStatus <= ST_UNSUP_ERR;
        end else if (badCnt) begin
          doneValid  <= 1'b1;
          doneStatus <= ST_SUBMIT_ERR;
        end else begin
          running <= 1'b1;
        end
      end else if (fire) begin
        evtPulse <= evtNow;
        if (finalBeat) begin
          running    <= 1'b0;
          doneValid  <= 1'b1;
          doneStatus <= ST_OK;
        end else begin
          for (int l = 0; l < LEVELS; l++) begin
            if (l < int'(carryLvl))       idx[l] <= '0;
            else if (l == int'(carryLvl)) idx[l] <= idx[l] + 1'b1;
          end
        end
      end
    end
  end

  assert_no_beat_when_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !beatValid);
  assert_hold_under_stall_R11: assert property (@(posedge clk) disable iff (!rstN)
    beatValid && !beatReady |=> beatValid && $stable(beatLast));
  assert_done_after_last_R5: assert property (@(posedge clk) disable iff (!rstN)
    fire && beatLast |=> doneValid && doneStatus == ST_OK && reqReady);
  assert_zero_count_reject_R6: assert property (@(posedge clk) disable iff (!rstN)
    accept && !badType && reqCnt[0] == '0 |=> doneValid && doneStatus == ST_SUBMIT_ERR && !beatValid);
  assert_bad_type_reject_R7: assert property (@(posedge clk) disable iff (!rstN)
    accept && inType > 4'd3 |=> doneValid && doneStatus == ST_UNSUP_ERR && !beatValid);
endmodule

// File: rtl/nd_addr_gen_dp.sv
module nd_addr_gen_dp
  import nd_addr_gen_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int STRIDE_W = 32
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  dp_strobe_t                      strb,
  input  logic [ADDR_W-1:0]               startAddr,
  input  logic [LEVELS-1:1][STRIDE_W-1:0] strides,
  output logic [ADDR_W-1:0]               beatAddr
);
  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] baseQ   [1:LEVELS-1];
  logic [ADDR_W-1:0] strideQ [1:LEVELS-1];
  logic [ADDR_W-1:0] nextBase;

  always_comb begin
    nextBase = '0;
    for (int k = 1; k < LEVELS; k++)
      if (int'(strb.level) == k) nextBase = baseQ[k] + strideQ[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addrQ <= '0;
    else if (strb.load) addrQ <= startAddr;
    else if (strb.advance) addrQ <= (strb.level == '0) ? addrQ + 1'b1 : nextBase;
  end

  for (genvar k = 1; k < LEVELS; k++) begin : g_level
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseQ[k]   <= '0;
        strideQ[k] <= '0;
      end else if (strb.load) begin
        baseQ[k]   <= startAddr;
        strideQ[k] <= ADDR_W'(signed'(strides[k]));
      end else if (strb.advance && int'(strb.level) >= k) begin
        baseQ[k] <= nextBase;
      end
    end
  end

  assign beatAddr = addrQ;

  assert_inner_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance && strb.level == '0 |=> beatAddr == $past(beatAddr) + 1'b1);
endmodule

// File: rtl/nd_addr_gen.sv
module nd_addr_gen
  import nd_addr_gen_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 16,
  parameter int STRIDE_W = 32
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            reqValid,
  output logic                            reqReady,
  input  logic [31:0]                     reqFlags,
  input  logic [ADDR_W-1:0]               reqAddr,
  input  logic [LEVELS-1:0][CNT_W-1:0]    reqCnt,
  input  logic [LEVELS-1:1][STRIDE_W-1:0] reqStride,
  input  logic [2:0]                      trigSrc,
  output logic                            beatValid,
  input  logic                            beatReady,
  output logic [ADDR_W-1:0]               beatAddr,
  output logic                            beatLast,
  output logic                            evtPulse,
  output logic                            doneValid,
  output logic [3:0]                      doneStatus,
  output logic [7:0]                      doneCmd
);
  dp_strobe_t strb;

  nd_addr_gen_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqFlags(reqFlags), .reqCnt(reqCnt), .trigSrc(trigSrc),
    .beatValid(beatValid), .beatReady(beatReady), .beatLast(beatLast),
    .evtPulse(evtPulse), .doneValid(doneValid), .doneStatus(doneStatus),
    .doneCmd(doneCmd), .strb(strb)
  );

  nd_addr_gen_dp #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .startAddr(reqAddr),
    .strides(reqStride), .beatAddr(beatAddr)
  );
endmodule

// File: tb/nd_addr_gen_tb_top.sv
`timescale 1ns/1ps
module nd_addr_gen_tb_top;
  localparam int ADDR_W = 32, CNT_W = 16, STRIDE_W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic reqValid = 1'b0;
  logic reqReady;
  logic [31:0] reqFlags = '0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [3:0][CNT_W-1:0] reqCnt = '0;
  logic [3:1][STRIDE_W-1:0] reqStride = '0;
  logic [2:0] trigSrc = '0;
  logic beatValid, beatLast, evtPulse, doneValid;
  logic beatReady = 1'b0;
  logic [ADDR_W-1:0] beatAddr;
  logic [3:0] doneStatus;
  logic [7:0] doneCmd;

  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;
  logic [31:0] eAddr [256];
  bit eLast [256];
  bit eEvt [256];
  int eN;

  nd_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STRIDE_W(STRIDE_W)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqFlags(reqFlags), .reqAddr(reqAddr), .reqCnt(reqCnt), .reqStride(reqStride),
    .trigSrc(trigSrc), .beatValid(beatValid), .beatReady(beatReady),
    .beatAddr(beatAddr), .beatLast(beatLast), .evtPulse(evtPulse),
    .doneValid(doneValid), .doneStatus(doneStatus), .doneCmd(doneCmd)
  );

  task automatic chkEq(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic endRun();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  // reference: closed-form address, last and event flags per beat
  task automatic buildExp(input logic [31:0] flags, input logic [31:0] start);
    int t, ev;
    int c [4];
    t  = int'(flags[3:0]);
    ev = int'(flags[7:6]);
    for (int l = 0; l < 4; l++)
      c[l] = (l == 0) ? int'(reqCnt[0]) : ((l <= t) ? ((reqCnt[l] == 0) ? 1 : int'(reqCnt[l])) : 1);
    eN = 0;
    for (int i3 = 0; i3 < c[3]; i3++)
      for (int i2 = 0; i2 < c[2]; i2++)
        for (int i1 = 0; i1 < c[1]; i1++)
          for (int i0 = 0; i0 < c[0]; i0++) begin
            bit lastB;
            lastB = (i0 == c[0]-1) && (i1 == c[1]-1) && (i2 == c[2]-1) && (i3 == c[3]-1);
            eAddr[eN] = start + 32'(i0) + 32'(i1) * reqStride[1] + 32'(i2) * reqStride[2]
                        + 32'(i3) * reqStride[3];
            eLast[eN] = lastB;
            if (ev == 0 || t < ev) eEvt[eN] = lastB;
            else eEvt[eN] = (i0 == c[0]-1) && (ev < 2 || i1 == c[1]-1) && (ev < 3 || i2 == c[2]-1);
            eN++;
          end
  endtask

  // ungated record; reqCnt and reqStride set by caller
  task automatic runGood(input logic [31:0] flags, input logic [31:0] start, input int readyPct);
    int k = 0;
    int guard = 0;
    bit expEvt = 0, expDone = 0, doneSeen = 0, held = 0;
    logic [31:0] heldAddr = '0;
    string evReq;
    evReq = (flags[7:6] == 0 || flags[3:0] < 4'(flags[7:6])) ? "R8" : "R9";
    buildExp(flags, start);
    @(negedge clk);
    reqFlags = flags; reqAddr = start; reqValid = 1'b1;
    chkEq("R1", "ready when idle", reqReady, 1);
    @(negedge clk);
    reqValid = 1'b0;
    chkEq("R1", "first beat next cycle", beatValid, 1);
    chkEq("R1", "first beat address", beatAddr, start);
    while (!doneSeen && guard < 5000) begin
      guard++;
      chkEq(evReq, "event pulse", evtPulse, expEvt);
      if (expDone) begin
        chkEq("R5", "done strobe", doneValid, 1);
        chkEq("R5", "done status", doneStatus, 0);
        chkEq("R2", "command id", doneCmd, flags[23:16]);
        doneSeen = 1;
      end else begin
        chkEq("R5", "no early done", doneValid, 0);
      end
      if (held) begin
        chkEq("R11", "held valid", beatValid, 1);
        chkEq("R11", "held address", beatAddr, heldAddr);
      end
      beatReady = (($urandom % 100) < readyPct);
      held = 0; expEvt = 0; expDone = 0;
      if (beatValid && beatReady) begin
        if (k < eN) begin
          chkEq("R3", "beat address", beatAddr, eAddr[k]);
          chkEq("R5", "last flag", beatLast, eLast[k]);
          expEvt = eEvt[k]; expDone = eLast[k];
        end
        k++;
      end else if (beatValid) begin
        held = 1; heldAddr = beatAddr;
      end
      @(negedge clk);
    end
    chkEq("R4", "beat count", k, eN);
    beatReady = 1'b0;
  endtask

  task automatic runBad(input logic [31:0] flags, input logic [15:0] cnt0, input logic [3:0] expSt, input string req);
    @(negedge clk);
    reqFlags = flags; reqCnt = '0; reqCnt[0] = cnt0; reqCnt[1] = 16'd2;
    reqAddr = 32'hABC0; reqValid = 1'b1; beatReady = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chkEq(req, "reject strobe", doneValid, 1);
    chkEq(req, "reject status", doneStatus, expSt);
    chkEq("R2", "reject command id", doneCmd, flags[23:16]);
    for (int i = 0; i < 3; i++) begin
      chkEq(req, "no beats after reject", beatValid, 0);
      chkEq(req, "idle after reject", reqReady, 1);
      @(negedge clk);
    end
    beatReady = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL R1 watchdog: actual hung expected finish");
    endRun();
  end

  initial begin
    void'($urandom(32'd20517));
    repeat (3) @(negedge clk);
    chkEq("R1", "reset ready", reqReady, 1);
    chkEq("R1", "reset beat", beatValid, 0);
    chkEq("R5", "reset done", doneValid, 0);
    chkEq("R8", "reset event", evtPulse, 0);
    rstN = 1'b1;
    @(negedge clk);

    // 1-D, completion event
    reqCnt = '0; reqCnt[0] = 16'd5;
    runGood({8'h00, 8'h11, 8'h00, 8'h00}, 32'h100, 100);
    // R4 type 0 ignores outer counts; R8 event size 3 falls back to last beat
    reqCnt = '0; reqCnt[0] = 16'd4; reqCnt[1] = 16'd3; reqCnt[2] = 16'd3; reqStride[1] = 32'h40;
    runGood({8'hFF, 8'h22, 8'h00, 8'hF0}, 32'h200, 100);
    // 4-D with zero level-2 count, event per level-2 decrement (R9), stalls
    reqCnt[0] = 16'd2; reqCnt[1] = 16'd2; reqCnt[2] = 16'd0; reqCnt[3] = 16'd2;
    reqStride[1] = 32'h10; reqStride[2] = 32'hFFFF_FF00; reqStride[3] = 32'h1000;
    runGood({8'h00, 8'h33, 8'h00, 8'h83}, 32'h8000, 60);
    // 3-D, negative level-1 stride, event per level-1 decrement
    reqCnt = '0; reqCnt[0] = 16'd3; reqCnt[1] = 16'd2; reqCnt[2] = 16'd2;
    reqStride[1] = 32'hFFFF_FFFC; reqStride[2] = 32'h20;
    runGood({8'h00, 8'h44, 8'h00, 8'h42}, 32'h0000_0002, 80);

    // rejects
    runBad({8'h00, 8'h55, 8'h00, 8'h02}, 16'd0, 4'd3, "R6");
    runBad({8'h00, 8'h66, 8'h00, 8'h09}, 16'd0, 4'd4, "R7");
    runBad({8'h00, 8'h77, 8'h00, 8'h0F}, 16'd4, 4'd4, "R7");

    // R10: slot 0 on global 0, one pulse per level-1 decrement
    reqCnt = '0; reqCnt[0] = 16'd3; reqCnt[1] = 16'd2; reqStride[1] = 32'hFFFF_FFC0;
    beatReady = 1'b1;
    @(negedge clk);
    reqFlags = {8'h00, 8'h5A, 8'h01, 8'h41}; reqAddr = 32'h1000; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chkEq("R10", "waits for trigger", beatValid, 0);
      @(negedge clk);
    end
    trigSrc = 3'b010;
    @(negedge clk);
    trigSrc = 3'b000;
    chkEq("R10", "unselected source ignored", beatValid, 0);
    @(negedge clk);
    chkEq("R10", "still waiting", beatValid, 0);
    trigSrc = 3'b001;
    @(negedge clk);
    trigSrc = 3'b000;
    for (int b = 0; b < 3; b++) begin
      chkEq("R10", "released block valid", beatValid, 1);
      chkEq("R3", "gated block address", beatAddr, 32'h1000 + 32'(b));
      @(negedge clk);
    end
    chkEq("R10", "second block waits", beatValid, 0);
    chkEq("R9", "event at level-1 decrement", evtPulse, 1);
    trigSrc = 3'b001;
    @(negedge clk);
    trigSrc = 3'b000;
    for (int b = 0; b < 3; b++) begin
      chkEq("R10", "second block valid", beatValid, 1);
      chkEq("R3", "negative stride address", beatAddr, 32'h0FC0 + 32'(b));
      chkEq("R5", "gated last flag", beatLast, b == 2);
      @(negedge clk);
    end
    chkEq("R5", "gated done", doneValid, 1);
    chkEq("R2", "gated command id", doneCmd, 8'h5A);
    chkEq("R9", "final event", evtPulse, 1);

    // R10: slot 1 on local source, whole-request granularity
    reqCnt = '0; reqCnt[0] = 16'd2; reqCnt[1] = 16'd2; reqStride[1] = 32'h8;
    @(negedge clk);
    reqFlags = {8'h00, 8'h3C, 8'hF0, 8'h01}; reqAddr = 32'h2000; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chkEq("R10", "whole request waits", beatValid, 0);
    trigSrc = 3'b100;
    @(negedge clk);
    trigSrc = 3'b000;
    for (int b = 0; b < 4; b++) begin
      chkEq("R10", "whole request streams", beatValid, 1);
      chkEq("R3", "whole request address", beatAddr, 32'h2000 + 32'((b / 2) * 8 + (b % 2)));
      @(negedge clk);
    end
    chkEq("R5", "whole request done", doneValid, 1);
    beatReady = 1'b0;

    // random records
    for (int n = 0; n < 40; n++) begin
      logic [31:0] fl;
      fl = $urandom;
      fl[3:0] = 4'($urandom % 4);
      fl[15:8] = 8'h00;
      reqCnt[0] = 16'(1 + $urandom % 4);
      for (int l = 1; l < 4; l++) reqCnt[l] = 16'($urandom % 4);
      for (int l = 1; l < 4; l++) reqStride[l] = 32'($signed($urandom % 8192) - 4096);
      runGood(fl, $urandom, 40 + int'($urandom % 61));
    end
    endRun();
  end
endmodule